// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking and Idle Timeout

This block decides which of five masters owns a shared parallel bus. Each master pulls its request line low to ask for the bus. The arbiter answers by pulling exactly one grant line low. Ownership rotates in circular order among the masters that are asking. When nobody asks, the grant stays parked on the last owner, so the bus always has a driver.

A granted master is expected to start a transaction soon. If the bus stays idle for more than a fixed number of cycles while that master keeps requesting, the arbiter marks the master broken. A broken master is left out of arbitration until it releases its request. Arbitration is hidden: while a transaction runs, the grant can already move to the next requester. A single `bus_idle` input tells the arbiter whether the bus is idle (1) or a transaction is in progress (0).

Top module: `rr_park_arbiter`

## Requirements
- R1: After reset the grant rests on master 0, so `gnt_n` reads 5'b11110. Bit i of `req_n` and of `gnt_n` belongs to master i, and both are active low.
- R2: From reset onward, exactly one bit of `gnt_n` is low in every cycle.
- R3: When all five masters request and the bus is busy, the grant visits masters in the order 1, 2, 3, 4, 0, 1, moving one position per clock starting from the reset owner.
- R4: If no master is eligible, the grant keeps its current owner. A master is eligible when it requests and is not broken. This still holds when the only requesters are broken.
- R5: While the owner requests, is not broken and the bus is idle, the grant stays on that owner, even when other masters request.
- R6: In any cycle where R5 does not hold, the grant moves to the first eligible master after the owner in circular order. The owner itself is checked last. This includes cycles where the bus is busy and the owner still requests.
- R7: When the hold condition of R5 has held for 16 consecutive cycles since the owner was granted, the owner becomes broken at that edge. The grant passes on at the next edge if another master is eligible.
- R8: A broken master never receives the grant while it keeps requesting.
- R9: A broken master returns to normal arbitration once its request is sampled high for at least one cycle.
- R10: A busy cycle or a change of owner restarts the idle count. Fifteen idle cycles, then one busy cycle, then fifteen more idle cycles leave the owner not broken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 5 | Bus requests, active low, bit i for master i |
| bus_idle | input | 1 | 1 when no transaction is in progress |
| gnt_n | output | 5 | Registered bus grants, active low, one low at a time |

## Verification
The hardest state to reach is the broken master. It needs one requester to hold the grant through sixteen unbroken idle cycles. Any competing request on a busy cycle, or any change of owner, silently restarts the count. The stimulus therefore keeps a single master requesting while the bus stays idle. It inserts one busy cycle to prove that the count restarts. Only then does it add a second requester, so the moment the first master is declared broken shows up as the grant jumping away. A long random phase holds each request pattern for many cycles with a mostly idle bus, so timeouts and recoveries also occur mixed with rotation.

// File: rtl/rr_park_arbiter.sv
module rr_park_arbiter #(
  parameter int N = 5,
  parameter int IDLE_LIMIT = 15,
  localparam int OW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         bus_idle,
  output logic [N-1:0] gnt_n
);

  logic [OW-1:0] owner, pick, nxt;
  logic [N-1:0]  broken, elig, mark;
  logic [CW-1:0] idle_cnt;
  logic          hold, expire;

  assign elig   = ~req_n & ~broken;
  assign hold   = ~req_n[owner] & ~broken[owner] & bus_idle;
  assign expire = hold && (idle_cnt == CW'(IDLE_LIMIT));
  assign mark   = expire ? (N'(1) << owner) : '0;
  assign nxt    = hold ? owner : pick;

  always_comb begin
    pick = owner;
    for (int k = N; k >= 1; k--)
      if (elig[(int'(owner) + k) % N]) pick = OW'((int'(owner) + k) % N);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner    <= '0;
      gnt_n    <= ~N'(1);
      broken   <= '0;
      idle_cnt <= '0;
    end else begin
      owner    <= nxt;
      gnt_n    <= ~(N'(1) << nxt);
      broken   <= (broken | mark) & ~req_n;
      idle_cnt <= (hold && !expire) ? idle_cnt + 1'b1 : '0;
    end
  end

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_n) == N - 1);

  a_r4_park: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |=> $stable(gnt_n));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(gnt_n));

  a_r7_mark: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> broken[$past(owner)]);

  a_r8_skip_broken: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gnt_n) |-> ((~gnt_n & $past(broken)) == '0));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (broken & $past(req_n)) == '0);

endmodule

// File: tb/tb_rr_park_arbiter.sv
module tb_rr_park_arbiter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] req_n = 5'h1F;
  logic       bus_idle = 1;
  logic [4:0] gnt_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  int m_owner = 0, m_cnt = 0;
  bit m_brk[5];

  always #5 clk = ~clk;

  rr_park_arbiter dut (.clk(clk), .rst_n(rst_n), .req_n(req_n), .bus_idle(bus_idle), .gnt_n(gnt_n));

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt_n=%b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit h;
    int nx;
    h = !req_n[m_owner] && !m_brk[m_owner] && bus_idle;
    nx = m_owner;
    if (h) begin
      if (m_cnt == 15) begin m_brk[m_owner] = 1; m_cnt = 0; end
      else m_cnt++;
    end else begin
      for (int k = 1; k <= 5; k++) begin
        int i;
        i = (m_owner + k) % 5;
        if (!req_n[i] && !m_brk[i]) begin nx = i; break; end
      end
      m_cnt = 0;
    end
    for (int i = 0; i < 5; i++) if (req_n[i]) m_brk[i] = 0;
    m_owner = nx;
  endtask

  task automatic step(input logic [4:0] mask, input bit idl);
    req_n = ~mask;
    bus_idle = idl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(gnt_n, ~(5'b1 << m_owner), tag);
    n_cmp++;
    if ($countones(gnt_n) != 4) begin
      n_bad++;
      $display("FAIL R2: gnt_n=%b expected exactly one low bit", gnt_n);
    end
  endtask

  function automatic logic [4:0] g(input int m);
    return ~(5'b1 << m);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(gnt_n, 5'b11110, "R1");

    tag = "R4";
    repeat (3) step(5'b00000, 1);
    check(gnt_n, g(0), "R4");

    tag = "R3";
    for (int s = 0; s < 6; s++) begin
      step(5'b11111, 0);
      check(gnt_n, g((s + 1) % 5), "R3");
    end

    tag = "R5";
    step(5'b10100, 1);
    check(gnt_n, g(2), "R6");
    repeat (5) step(5'b10100, 1);
    check(gnt_n, g(2), "R5");
    tag = "R6";
    step(5'b10100, 0);
    check(gnt_n, g(4), "R6");

    tag = "R10";
    step(5'b01000, 1);
    check(gnt_n, g(3), "R6");
    repeat (15) step(5'b01000, 1);
    step(5'b01000, 0);
    repeat (15) step(5'b01001, 1);
    check(gnt_n, g(3), "R10");
    tag = "R7";
    step(5'b01001, 1);
    check(gnt_n, g(3), "R7");
    step(5'b01001, 1);
    check(gnt_n, g(0), "R7");

    tag = "R8";
    repeat (4) step(5'b01000, 0);
    check(gnt_n, g(0), "R8");
    tag = "R9";
    step(5'b00000, 0);
    step(5'b01000, 0);
    check(gnt_n, g(3), "R9");

    tag = "R2";
    for (int b = 0; b < 400; b++) begin
      logic [4:0] m;
      int len;
      m = 5'($urandom);
      len = 1 + $urandom % 24;
      for (int c = 0; c < len; c++) step(m, ($urandom % 5) != 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule